// File: doc/BRIEF.md
# Grouped external interrupt controller

This block watches sixteen external interrupt pins and turns their activity into three interrupt requests for a processor. Every pin first crosses into the block's clock domain through a two-flop synchronizer. It is then tested against a trigger condition. Neighbouring pins share one trigger setting: pins 2k and 2k+1 use the same type field. When a pin meets its condition, its pending flag is set and stays set until software clears it.

A per-pin mask decides whether a pending flag may reach the outputs. The unmasked flags are merged into three outputs that cover groups of unequal size. The first output serves pins 0 to 3, the second serves pins 4 to 11, and the third serves pins 12 to 15. Software identifies the source by reading the raw pending flags and applying its own copy of the mask.

Software reaches the block through a small register port. Each access completes in the cycle it is presented and is never stalled, so the port has no back-pressure: a write takes effect at the next clock edge, and read data is valid in the same cycle as the read strobe. The pin and interrupt lines are plain level signals with no handshake.

Top module: `xint_ctrl`

## Requirements
- R1: The configuration register at byte offset 0x0 holds one 3-bit type field per pin pair k (pins 2k and 2k+1), in bits 4k+2..4k. Bit 4k+3 of every slot is not stored and reads as 0, so writing 0xFFFFFFFF reads back 0x77777777.
- R2: Type codes: 000 is active-low level, 001 is active-high level, 010 is falling edge, 100 is rising edge and 110 is both edges. The codes 011, 101 and 111 disable detection for that pair.
- R3: The pin is sampled by a two-flop synchronizer, and an edge is detected by comparing the synchronized value with its value one cycle earlier. For a pin change made between clock edges, the pending flag and the affected group output become 1 after the third rising edge and not before.
- R4: In level mode, the pending flag is set again on every cycle in which the active level is present. A clear therefore has no lasting effect until the pin goes inactive.
- R5: Pending register at byte offset 0x8: writing 1 to a bit clears that flag, and writing 0 leaves it unchanged. If a set and a clear fall in the same cycle, the set wins. After an edge trigger a clear is lasting.
- R6: Mask register at byte offset 0x4, bits 15..0: 1 blocks a pin from the group outputs and 0 passes it. A masked pin still becomes pending, and reads of the pending register return the raw flags. Bits 31..16 read as 0.
- R7: The output grp_irq[0] is the OR of the unmasked pending flags of pins 0..3, grp_irq[1] covers pins 4..11 and grp_irq[2] covers pins 12..15.
- R8: While reset is held, configuration reads 0, mask reads 0xFFFF, pending reads 0 and grp_irq is 0.
- R9: Reads at byte offsets other than 0x0, 0x4 and 0x8 return 0. Writes there change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_pin | input | 16 | Asynchronous external interrupt pins |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as a read strobe |
| grp_irq | output | 3 | Group interrupt requests: bit 0 for pins 0-3, bit 1 for pins 4-11, bit 2 for pins 12-15 |

## Verification
Faults in the synchronizer or in the stored previous sample show up as a shift in latency or as a missed edge. A pending flag then appears one cycle early or late, or not at all, at the group output three edges after the pin moves. A damaged pending register or a wrong clear priority appears on the next register read. It shows as a flag that survives a clear after an edge trigger, or as a level flag that drops while its pin is still active. A mask or group decoding error is visible at grp_irq in the same cycle as the faulty state.

// File: rtl/xint_pkg.sv
package xint_pkg;
  localparam int NUM_LINES  = 16;
  localparam int TYPE_W     = 3;
  localparam int SLOT_W     = 4;
  localparam int PAIR_CNT   = NUM_LINES / 2;
  localparam int CFG_W      = PAIR_CNT * SLOT_W;
  localparam int DATA_W     = 32;
  localparam int ADDR_W     = 4;
  localparam int GROUP_CNT  = 3;

  localparam logic [ADDR_W-1:0] OFF_CFG  = 4'h0;
  localparam logic [ADDR_W-1:0] OFF_MASK = 4'h4;
  localparam logic [ADDR_W-1:0] OFF_PEND = 4'h8;

  typedef enum logic [TYPE_W-1:0] {
    TRIG_LOW  = 3'b000,
    TRIG_HIGH = 3'b001,
    TRIG_FALL = 3'b010,
    TRIG_RISE = 3'b100,
    TRIG_BOTH = 3'b110
  } trig_e;

  // evaluate one line against its pair's trigger type
  function automatic logic trig_hit(input logic [TYPE_W-1:0] code,
                                    input logic cur, input logic prev);
    logic r;
    case (code)
      TRIG_LOW:  r = ~cur;
      TRIG_HIGH: r = cur;
      TRIG_FALL: r = prev & ~cur;
      TRIG_RISE: r = ~prev & cur;
      TRIG_BOTH: r = prev ^ cur;
      default:   r = 1'b0;
    endcase
    return r;
  endfunction

  // bits kept in the configuration register: low TYPE_W bits of each slot
  function automatic logic [CFG_W-1:0] cfg_keep();
    logic [CFG_W-1:0] k;
    k = '0;
    for (int p = 0; p < PAIR_CNT; p++)
      for (int b = 0; b < TYPE_W; b++)
        k[p*SLOT_W + b] = 1'b1;
    return k;
  endfunction
endpackage

// File: rtl/xint_sync.sv
module xint_sync #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1   <= '0;
      sync_out <= '0;
    end else begin
      stage1   <= async_in;
      sync_out <= stage1;
    end
  end
endmodule

// File: rtl/xint_detect.sv
module xint_detect
  import xint_pkg::*;
#(
  parameter int N = NUM_LINES
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [N-1:0]          lvl,
  input  logic [(N/2)*SLOT_W-1:0] cfg,
  output logic [N-1:0]          hit
);
  localparam int PAIRS = N / 2;

  logic [N-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= lvl;
  end

  for (genvar p = 0; p < PAIRS; p++) begin : g_pair
    logic [TYPE_W-1:0] code;
    assign code = cfg[p*SLOT_W +: TYPE_W];
    for (genvar j = 0; j < 2; j++) begin : g_line
      assign hit[2*p+j] = trig_hit(code, lvl[2*p+j], prev_q[2*p+j]);
    end
  end
endmodule

// File: rtl/xint_regs.sv
module xint_regs
  import xint_pkg::*;
#(
  parameter int N = NUM_LINES
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    bus_sel,
  input  logic                    bus_wr,
  input  logic [ADDR_W-1:0]       bus_addr,
  input  logic [DATA_W-1:0]       bus_wdata,
  output logic [DATA_W-1:0]       bus_rdata,
  input  logic [N-1:0]            hit,
  output logic [(N/2)*SLOT_W-1:0] cfg_q,
  output logic [N-1:0]            mask_q,
  output logic [N-1:0]            pend_q
);
  localparam int CW = (N/2)*SLOT_W;
  localparam logic [CW-1:0] KEEP = cfg_keep();

  logic wr_cfg, wr_mask, wr_pend;
  logic [N-1:0] clr_bits;

  assign wr_cfg  = bus_sel && bus_wr && (bus_addr == OFF_CFG);
  assign wr_mask = bus_sel && bus_wr && (bus_addr == OFF_MASK);
  assign wr_pend = bus_sel && bus_wr && (bus_addr == OFF_PEND);
  assign clr_bits = wr_pend ? bus_wdata[N-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      mask_q <= '1;
      pend_q <= '0;
    end else begin
      if (wr_cfg)  cfg_q  <= bus_wdata[CW-1:0] & KEEP;
      if (wr_mask) mask_q <= bus_wdata[N-1:0];
      // a new event wins over a clear in the same cycle
      pend_q <= (pend_q & ~clr_bits) | hit;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_wr) begin
      case (bus_addr)
        OFF_CFG:  bus_rdata[CW-1:0] = cfg_q;
        OFF_MASK: bus_rdata[N-1:0]  = mask_q;
        OFF_PEND: bus_rdata[N-1:0]  = pend_q;
        default:  bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/xint_group.sv
module xint_group
  import xint_pkg::*;
#(
  parameter int N      = NUM_LINES,
  parameter int A_LAST = 3,
  parameter int B_LAST = 11
) (
  input  logic [N-1:0]         pend,
  input  logic [N-1:0]         mask,
  output logic [GROUP_CNT-1:0] grp
);
  localparam int LO [GROUP_CNT] = '{0, A_LAST + 1, B_LAST + 1};
  localparam int HI [GROUP_CNT] = '{A_LAST, B_LAST, N - 1};

  function automatic logic [N-1:0] span(input int lo, input int hi);
    logic [N-1:0] s;
    s = '0;
    for (int i = 0; i < N; i++)
      if (i >= lo && i <= hi) s[i] = 1'b1;
    return s;
  endfunction

  logic [N-1:0] live;
  assign live = pend & ~mask;

  for (genvar g = 0; g < GROUP_CNT; g++) begin : g_grp
    localparam logic [N-1:0] SEL = span(LO[g], HI[g]);
    assign grp[g] = |(live & SEL);
  end
endmodule

// File: rtl/xint_ctrl.sv
module xint_ctrl
  import xint_pkg::*;
#(
  parameter int N      = NUM_LINES,
  parameter int A_LAST = 3,
  parameter int B_LAST = 11
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N-1:0]         ext_pin,
  input  logic                 bus_sel,
  input  logic                 bus_wr,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [DATA_W-1:0]    bus_wdata,
  output logic [DATA_W-1:0]    bus_rdata,
  output logic [GROUP_CNT-1:0] grp_irq
);
  localparam int CW = (N/2)*SLOT_W;

  logic [N-1:0]  pin_sync;
  logic [N-1:0]  hit_vec;
  logic [CW-1:0] cfg_q;
  logic [N-1:0]  mask_q;
  logic [N-1:0]  pend_q;

  xint_sync #(.W(N)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(ext_pin), .sync_out(pin_sync)
  );

  xint_detect #(.N(N)) u_detect (
    .clk(clk), .rst_n(rst_n), .lvl(pin_sync), .cfg(cfg_q), .hit(hit_vec)
  );

  xint_regs #(.N(N)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .hit(hit_vec), .cfg_q(cfg_q), .mask_q(mask_q), .pend_q(pend_q)
  );

  xint_group #(.N(N), .A_LAST(A_LAST), .B_LAST(B_LAST)) u_group (
    .pend(pend_q), .mask(mask_q), .grp(grp_irq)
  );
endmodule

// File: rtl/xint_ctrl_chk.sv
module xint_ctrl_chk
  import xint_pkg::*;
#(
  parameter int N = NUM_LINES
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 bus_sel,
  input logic                 bus_wr,
  input logic [ADDR_W-1:0]    bus_addr,
  input logic [DATA_W-1:0]    bus_rdata,
  input logic [GROUP_CNT-1:0] grp_irq,
  input logic [N-1:0]         mask_q,
  input logic [N-1:0]         pend_q,
  input logic [N-1:0]         hit
);
  localparam logic [DATA_W-1:0] PAD = 32'h88888888;

  // R6: with every line masked, no group output may be active
  p_all_masked_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '1) |-> (grp_irq == '0));

  // R5: a pending flag only falls after a write to the pending register
  p_fall_needs_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(pend_q) & ~pend_q) != '0) |->
      $past(bus_sel && bus_wr && (bus_addr == OFF_PEND)));

  // R3: a pending flag only rises after a detected trigger
  p_rise_needs_hit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend_q & ~$past(pend_q) & ~$past(hit)) == '0));

  // R1: unused slot bits of the configuration register read as zero
  p_cfg_pad_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && (bus_addr == OFF_CFG)) |-> ((bus_rdata & PAD) == '0));

  // R9: an unused offset reads zero
  p_unused_read_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && (bus_addr != OFF_CFG) && (bus_addr != OFF_MASK) &&
     (bus_addr != OFF_PEND)) |-> (bus_rdata == '0));
endmodule

bind xint_ctrl xint_ctrl_chk #(.N(N)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_rdata(bus_rdata), .grp_irq(grp_irq),
  .mask_q(mask_q), .pend_q(pend_q), .hit(hit_vec)
);

// File: tb/test_xint_ctrl.sv
module test_xint_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] ext_pin = 16'hFFFF;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [3:0]  bus_addr = 4'h0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [2:0]  grp_irq;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  always #2 clk = ~clk;

  xint_ctrl i_xint_ctrl (
    .clk(clk), .rst_n(rst_n), .ext_pin(ext_pin), .bus_sel(bus_sel),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .grp_irq(grp_irq)
  );

  // fields: cfg[98:67] mask[66:51] before[50:35] after[34:19] pend[18:3] grp[2:0]
  localparam int NV = 9;
  localparam logic [98:0] VEC [NV] = '{
    {32'h77777774, 16'h0000, 16'h0000, 16'h0003, 16'h0003, 3'b001}, // R2 rise, R7 A
    {32'h77777727, 16'h0000, 16'hFFFF, 16'hFFF3, 16'h000C, 3'b001}, // R2 fall
    {32'h77776777, 16'h0040, 16'h0040, 16'h0080, 16'h00C0, 3'b010}, // R2 both, R6
    {32'h17777777, 16'h8000, 16'h0000, 16'h8000, 16'h8000, 3'b000}, // R2 high, R6
    {32'h77077777, 16'h0000, 16'hFFFF, 16'hFBFF, 16'h0400, 3'b010}, // R2 low, R7 B
    {32'h73777777, 16'h0000, 16'h0000, 16'h3000, 16'h0000, 3'b000}, // R2 code 011 off
    {32'h75777777, 16'h0000, 16'h3000, 16'h0000, 16'h0000, 3'b000}, // R2 code 101 off
    {32'h44444444, 16'h0000, 16'h0000, 16'h1111, 16'h1111, 3'b111}, // R7 all groups
    {32'h44444444, 16'h0010, 16'h0000, 16'h0010, 16'h0010, 3'b000}  // R6 masked
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic report();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      report();
    end
  end

  initial begin
    logic [31:0] d;
    // R8: reset values, read while reset is held
    idle(3);
    rd(4'h0, d); check("R8 cfg reset", d, 32'h0);
    rd(4'h4, d); check("R8 mask reset", d, 32'h0000FFFF);
    rd(4'h8, d); check("R8 pend reset", d, 32'h0);
    check("R8 grp reset", {29'b0, grp_irq}, 32'h0);
    @(negedge clk); rst_n = 1'b1;

    // R1: unused slot bits are not stored
    wr(4'h0, 32'hFFFFFFFF); rd(4'h0, d); check("R1 cfg pad", d, 32'h77777777);
    // R9: mask upper bits read zero, unused offset reads zero and writes do nothing
    wr(4'h4, 32'hFFFFFFFF); rd(4'h4, d); check("R9 mask upper", d, 32'h0000FFFF);
    wr(4'hC, 32'h00000000); rd(4'hC, d); check("R9 unused read", d, 32'h0);
    rd(4'h4, d); check("R9 unused write", d, 32'h0000FFFF);
    rd(4'h0, d); check("R9 unused write cfg", d, 32'h77777777);

    // vector table walk
    for (int v = 0; v < NV; v++) begin
      wr(4'h0, 32'h77777777);
      ext_pin = VEC[v][50:35];
      idle(5);
      wr(4'h8, 32'hFFFF);
      wr(4'h0, VEC[v][98:67]);
      wr(4'h4, {16'h0, VEC[v][66:51]});
      idle(2);
      wr(4'h8, 32'hFFFF);
      ext_pin = VEC[v][34:19];
      idle(5);
      rd(4'h8, d); check($sformatf("R2/R6 vec%0d pend", v), d, {16'h0, VEC[v][18:3]});
      check($sformatf("R7 vec%0d grp", v), {29'b0, grp_irq}, {29'b0, VEC[v][2:0]});
    end

    // R3: latency of three rising edges from a pin change
    wr(4'h0, 32'h77777777);
    ext_pin = 16'h0000;
    idle(5);
    wr(4'h4, 32'h0);
    wr(4'h0, 32'h77777774);
    wr(4'h8, 32'hFFFF);
    @(negedge clk); ext_pin = 16'h0001;
    @(negedge clk); @(negedge clk);
    check("R3 not before third edge", {31'b0, grp_irq[0]}, 32'h0);
    @(negedge clk);
    check("R3 after third edge", {31'b0, grp_irq[0]}, 32'h1);

    // R5: write 0 leaves, write 1 clears, edge clear is lasting
    wr(4'h8, 32'h0); rd(4'h8, d); check("R5 write zero keeps", d, 32'h1);
    wr(4'h8, 32'h1); rd(4'h8, d); check("R5 clear edge", d, 32'h0);
    idle(3); rd(4'h8, d); check("R5 clear lasting", d, 32'h0);

    // R4: level mode sets again while active
    wr(4'h0, 32'h77777771);
    idle(2);
    wr(4'h8, 32'h1); rd(4'h8, d); check("R4 level re-set", d, 32'h1);
    // R6: masked line still pending, group quiet
    wr(4'h4, 32'h1);
    rd(4'h8, d); check("R6 masked still pending", d, 32'h1);
    check("R6 masked group low", {29'b0, grp_irq}, 32'h0);
    wr(4'h4, 32'h0);
    check("R7 unmasked group A", {29'b0, grp_irq}, 32'h1);
    ext_pin = 16'h0000;
    idle(4);
    wr(4'h8, 32'h1); rd(4'h8, d); check("R4 clear after inactive", d, 32'h0);

    done = 1;
    report();
  end
endmodule